// File: doc/BRIEF.md
# Separable Gaussian Smoothing Filter

The block smooths a raster-scanned stream of 8-bit grayscale pixels with a 5x5 Gaussian kernel. The kernel is split into two identical one-dimensional passes. The first pass runs along each line with the integer weights 1, 3, 4, 3, 1. The second pass applies the same weights down each column. Four line stores hold the results of the first pass for the previous lines. Each pass divides its weighted sum by 12 and truncates the quotient, so every pass ends as an 8-bit value.

The windows are causal. An output pixel that leaves with input position (row r, column c) is built from columns c-4..c and rows r-4..r. A column left of the line start takes the value of the first pixel of that line. A row above the first row of the frame takes the value of that first row. Because of this the block needs no flush at the end of a frame, and every output keeps a fixed latency. A new line is marked by the line marker or the frame marker on its first pixel. A new frame is marked by the frame marker. The line length is a parameter, and the frame height is whatever the stream supplies.

Top module: `gauss_smooth`

## Requirements
- R1: While reset is held, and after its release until pixels have been accepted, validOut, sofOut and solOut are low.
- R2: A pixel accepted with validIn high at clock edge n produces exactly one output with validOut high, and that output is visible in the cycle after edge n+9 (10 register stages). Idle input cycles produce idle output cycles in the same places.
- R3: sofOut and solOut are validIn&sofIn and validIn&solIn delayed by the same 10 stages as validOut.
- R4: The first pass forms H = floor((p[c-4] + 3p[c-3] + 4p[c-2] + 3p[c-1] + p[c]) / 12) over the pixels of the current line, where p[c] is the newest pixel.
- R5: A line starts on a pixel that has solIn or sofIn set. The first-pass window does not reach back into the previous line: every column before the line start takes the value of its first pixel.
- R6: The output pixel is floor((H[r-4] + 3H[r-3] + 4H[r-2] + 3H[r-1] + H[r]) / 12), formed from the first-pass results of the same column in the current line and the four lines before it.
- R7: A pixel with sofIn set restarts the row count. In the second pass, every row before the first row of the frame takes the first-pass value of that first row.
- R8: The sums use their full width with no wrap. A frame of all 255 comes out as all 255, and a frame of all 0 comes out as all 0.
- R9: pixIn is ignored while validIn is low. It has no effect on any later output pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | pixIn carries a pixel this cycle |
| sofIn | input | 1 | First pixel of a frame (also starts a line) |
| solIn | input | 1 | First pixel of a line |
| pixIn | input | PIX_W | Input grayscale pixel, unsigned |
| validOut | output | 1 | pixOut carries a smoothed pixel |
| sofOut | output | 1 | Frame marker, aligned with pixOut |
| solOut | output | 1 | Line marker, aligned with pixOut |
| pixOut | output | PIX_W | Smoothed pixel |

## Verification
Every result of the block falls due exactly ten clock edges after the pixel that causes it: the smoothed value, both markers and the valid flag. When the bench drives a pixel, it enters the expected value and markers in a queue, together with the cycle number at which they must appear. The bench samples on the falling clock edge. If the output is valid, the bench checks that the current cycle equals the due cycle of the head of the queue, then compares the value and the markers. A missing output is reported as soon as its due cycle passes. The expected pixels come from an arithmetic model of the two passes with edge replication. They cover ramp, random, edge-step, flat and gapped frames.

// File: rtl/gauss_pkg.sv
package gauss_pkg;
  localparam int TAPS = 5;       // kernel length of one pass
  localparam int STAGE_LAT = 5;  // registers per pass: tap load + 4 convolver stages
  localparam int KSUM = 12;      // 1+3+4+3+1

  typedef struct packed {
    logic valid;
    logic sof;
    logic sol;
  } mark_t;

  typedef struct packed {
    logic hLoad;     // accept an input pixel into the horizontal window
    logic hRestart;  // first pixel of a line: replicate into every tap
    logic vLoad;     // accept a first-pass result into the vertical window
  } strobe_t;
endpackage

// File: rtl/gauss_conv1d.sv
module gauss_conv1d
  import gauss_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic [TAPS-1:0][DW-1:0]  taps,
  output logic [DW-1:0]            q
);
  localparam int PW = DW + 1;  // pair sum
  localparam int MW = DW + 2;  // centre times 4
  localparam int TW = DW + 3;  // partial sums
  localparam int SW = DW + 4;  // full weighted sum

  logic [PW-1:0] pairOuter, pairInner;
  logic [MW-1:0] centre4;
  logic [TW-1:0] innerX3, outerSum;
  logic [SW-1:0] total;
  logic [SW-1:0] quotient;

  // stage 1: symmetric pairs, centre shifted
  always_ff @(posedge clk) begin
    pairOuter <= {1'b0, taps[0]} + {1'b0, taps[4]};
    pairInner <= {1'b0, taps[1]} + {1'b0, taps[3]};
    centre4   <= {taps[2], 2'b00};
  end

  // stage 2: inner pair times 3 by shift-and-add, outer pair plus centre
  always_ff @(posedge clk) begin
    innerX3  <= {1'b0, pairInner, 1'b0} + {2'b00, pairInner};
    outerSum <= {2'b00, pairOuter} + {1'b0, centre4};
  end

  // stage 3: full sum, exact width
  always_ff @(posedge clk) begin
    total <= {1'b0, innerX3} + {1'b0, outerSum};
  end

  // stage 4: normalise by the coefficient sum, truncating
  assign quotient = total / SW'(KSUM);
  always_ff @(posedge clk) begin
    q <= quotient[DW-1:0];
  end
endmodule

// File: rtl/gauss_ctrl.sv
module gauss_ctrl
  import gauss_pkg::*;
#(
  parameter int W  = 64,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          validIn,
  input  logic          sofIn,
  input  logic          solIn,
  output strobe_t       stb,
  output logic [CW-1:0] col,
  output logic [2:0]    rowSel,
  output mark_t         markOut
);
  localparam int DLY = 2 * STAGE_LAT;

  mark_t dly [DLY];
  mark_t midM;
  logic  lineStart;
  logic [CW-1:0] colCnt;
  logic [2:0]    rowIdx, rowCur;

  // marker delay line, gated by valid (R3)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DLY; i++) dly[i] <= '0;
    end else begin
      dly[0] <= '{valid: validIn, sof: validIn & sofIn, sol: validIn & solIn};
      for (int i = 1; i < DLY; i++) dly[i] <= dly[i-1];
    end
  end

  assign midM      = dly[STAGE_LAT-1];
  assign lineStart = midM.sol | midM.sof;

  // column of the first-pass result now arriving
  assign col = lineStart ? '0 : colCnt;

  // row count since frame start, saturating at the window depth (R7)
  always_comb begin
    if (midM.sof)       rowCur = 3'd0;
    else if (lineStart) rowCur = (rowIdx == 3'(TAPS-1)) ? rowIdx : rowIdx + 3'd1;
    else                rowCur = rowIdx;
  end
  assign rowSel = rowCur;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowIdx <= '0;
    end else if (midM.valid) begin
      colCnt <= (col == CW'(W-1)) ? '0 : col + 1'b1;
      rowIdx <= rowCur;
    end
  end

  assign stb.hLoad    = validIn;
  assign stb.hRestart = validIn & (solIn | sofIn);
  assign stb.vLoad    = midM.valid;
  assign markOut      = dly[DLY-1];
endmodule

// File: rtl/gauss_dp.sv
module gauss_dp
  import gauss_pkg::*;
#(
  parameter int DW = 8,
  parameter int W  = 64,
  parameter int CW = 6
) (
  input  logic          clk,
  input  strobe_t       stb,
  input  logic [DW-1:0] pixIn,
  input  logic [CW-1:0] col,
  input  logic [2:0]    rowSel,
  output logic [DW-1:0] pixOut
);
  localparam int NLB = TAPS - 1;

  logic [TAPS-1:0][DW-1:0] hTap, vTap, cand;
  logic [DW-1:0] hOut;
  logic [DW-1:0] lineBuf [NLB][W];

  // horizontal window; line start fills all taps (R5), idle cycles hold (R9)
  always_ff @(posedge clk) begin
    if (stb.hLoad) begin
      if (stb.hRestart) hTap <= {TAPS{pixIn}};
      else              hTap <= {hTap[TAPS-2:0], pixIn};
    end
  end

  gauss_conv1d #(.DW(DW)) uRow (.clk(clk), .taps(hTap), .q(hOut));

  // candidates: current first-pass result and the same column of older lines
  assign cand[0] = hOut;
  for (genvar k = 1; k < TAPS; k++) begin : g_cand
    assign cand[k] = lineBuf[k-1][col];
  end

  always_ff @(posedge clk) begin
    if (stb.vLoad) begin
      lineBuf[0][col] <= hOut;
      for (int k = 1; k < NLB; k++) lineBuf[k][col] <= lineBuf[k-1][col];
    end
  end

  // vertical window; rows before the frame reuse the first row (R7)
  always_ff @(posedge clk) begin
    if (stb.vLoad) begin
      for (int k = 0; k < TAPS; k++)
        vTap[k] <= (3'(k) <= rowSel) ? cand[k] : cand[rowSel];
    end
  end

  gauss_conv1d #(.DW(DW)) uCol (.clk(clk), .taps(vTap), .q(pixOut));
endmodule

// File: rtl/gauss_smooth.sv
module gauss_smooth
  import gauss_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             validIn,
  input  logic             sofIn,
  input  logic             solIn,
  input  logic [PIX_W-1:0] pixIn,
  output logic             validOut,
  output logic             sofOut,
  output logic             solOut,
  output logic [PIX_W-1:0] pixOut
);
  localparam int CW = (LINE_W > 1) ? $clog2(LINE_W) : 1;

  strobe_t       stb;
  mark_t         markOut;
  logic [CW-1:0] col;
  logic [2:0]    rowSel;

  gauss_ctrl #(.W(LINE_W), .CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sofIn(sofIn), .solIn(solIn),
    .stb(stb), .col(col), .rowSel(rowSel), .markOut(markOut)
  );

  gauss_dp #(.DW(PIX_W), .W(LINE_W), .CW(CW)) uDp (
    .clk(clk), .stb(stb), .pixIn(pixIn), .col(col), .rowSel(rowSel), .pixOut(pixOut)
  );

  assign validOut = markOut.valid;
  assign sofOut   = markOut.sof;
  assign solOut   = markOut.sol;
endmodule

// File: rtl/gauss_smooth_chk.sv
module gauss_smooth_chk (
  input logic clk,
  input logic rstN,
  input logic validIn,
  input logic sofIn,
  input logic solIn,
  input logic validOut,
  input logic sofOut,
  input logic solOut
);
  logic [3:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 4'd15) sinceRst <= sinceRst + 4'd1;
  end

  // R2
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'd10) |-> (validOut == $past(validIn, 10)));

  // R3
  sof_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'd10) |-> (sofOut == $past(validIn && sofIn, 10)));

  // R3
  sol_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 4'd10) |-> (solOut == $past(validIn && solIn, 10)));

  // R1
  early_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst < 4'd10) |-> (!validOut && !sofOut && !solOut));

  // R3
  marker_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sofOut || solOut) |-> validOut);
endmodule

bind gauss_smooth gauss_smooth_chk uChk (
  .clk(clk), .rstN(rstN), .validIn(validIn), .sofIn(sofIn), .solIn(solIn),
  .validOut(validOut), .sofOut(sofOut), .solOut(solOut)
);

// File: tb/sim_gauss_smooth.sv
`timescale 1ns/1ps
module sim_gauss_smooth;
  localparam int W = 8;
  localparam int ROWS = 6;
  localparam int LAT = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validIn = 1'b0, sofIn = 1'b0, solIn = 1'b0;
  logic [7:0] pixIn = '0;
  logic validOut, sofOut, solOut;
  logic [7:0] pixOut;

  gauss_smooth #(.PIX_W(8), .LINE_W(W)) u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .sofIn(sofIn), .solIn(solIn),
    .pixIn(pixIn), .validOut(validOut), .sofOut(sofOut), .solOut(solOut), .pixOut(pixOut)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChk = 0, nBad = 0;
  bit done = 0;

  typedef struct { int val; int marks; int due; int fr; } exp_t;
  exp_t expQ[$];
  string tagOf[7] = '{"R4", "R6", "R5", "R7", "R8", "R8", "R9"};
  int img[ROWS][W];

  task automatic check(bit ok, string tag, int act, int expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  function automatic int wgt(int k);
    return (k == 2) ? 4 : ((k == 1 || k == 3) ? 3 : 1);
  endfunction

  function automatic int hres(int r, int c);
    int s = 0;
    for (int k = 0; k < 5; k++) s += wgt(k) * img[r][(c - k < 0) ? 0 : c - k];
    return s / 12;
  endfunction

  function automatic int vres(int r, int c);
    int s = 0;
    for (int k = 0; k < 5; k++) s += wgt(k) * hres((r - k < 0) ? 0 : r - k, c);
    return s / 12;
  endfunction

  task automatic fillFrame(int f);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < W; c++)
        case (f)
          0: img[r][c] = (r * 29 + c * 17) % 256;
          2: img[r][c] = (c == 0) ? 240 : 15 + r * 3;
          3: img[r][c] = (r == 0) ? 250 : 5 + c;
          4: img[r][c] = 255;
          5: img[r][c] = 0;
          default: img[r][c] = int'($urandom_range(0, 255));
        endcase
  endtask

  task automatic sendFrame(int f, bit gaps);
    fillFrame(f);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < W; c++) begin
        if (gaps && $urandom_range(0, 2) == 0) begin
          @(negedge clk);
          validIn = 1'b0; sofIn = 1'b1; solIn = 1'b1;
          pixIn = 8'($urandom_range(0, 255));  // R9: garbage while idle
        end
        @(negedge clk);
        validIn = 1'b1;
        pixIn = 8'(img[r][c]);
        sofIn = (r == 0 && c == 0);
        solIn = (c == 0);
        expQ.push_back('{val: vres(r, c), marks: {30'd0, sofIn, solIn}, due: cyc + LAT, fr: f});
      end
    @(negedge clk);
    validIn = 1'b0; sofIn = 1'b0; solIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // output comparison, sampled on the falling edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (validOut) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R2", 1, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          check(cyc == e.due, "R2", cyc, e.due);
          check({sofOut, solOut} == e.marks[1:0], "R3", {sofOut, solOut}, e.marks);
          check(pixOut == e.val[7:0], tagOf[e.fr], pixOut, e.val);
        end
      end else if (expQ.size() > 0 && expQ[0].due <= cyc) begin
        check(1'b0, "R2", 0, 1);
        void'(expQ.pop_front());
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!validOut && !sofOut && !solOut, "R1", {validOut, sofOut, solOut}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(!validOut && !sofOut && !solOut, "R1", {validOut, sofOut, solOut}, 0);
    end
    for (int f = 0; f < 6; f++) sendFrame(f, 1'b0);  // R4 R5 R6 R7 R8
    sendFrame(6, 1'b1);                              // R9 with idle gaps
    repeat (LAT + 5) @(negedge clk);
    check(expQ.size() == 0, "R2", expQ.size(), 0);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      done = 1;
      nChk++;
      nBad++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end
endmodule